// File: doc/BRIEF.md
# UART Receive Byte-to-Word Packer

This block sits behind a UART's bit-level receiver and groups the incoming bytes into 32-bit rows. The first byte of a row goes in the lowest byte lane. Rows wait in a small FIFO until the host reads them. A row that is only partly filled is not shown to the host until something closes it. A row closes when its fourth byte arrives, when a byte matches a configured match character, or when the line has been quiet for a programmed number of bit-time ticks. Every row also stores how many of its byte lanes hold data, so the host can read the data from a partly filled row.

The host side is a plain read port. `data_ready` means a row is waiting. `rd_word` and `rd_count` show that row, and a one-cycle `rd_strobe` removes it. The host reads two status flags and clears each one by writing a one to its bit: bit 0 is row-closed and bit 1 is overrun. To empty the receive side, the host reads rows until `data_ready` drops.

The byte input has a valid signal but no back-pressure. A UART cannot be held off, so every byte is taken in the cycle it is valid. If a byte would close a row while the FIFO has no free slot, that byte is dropped and the overrun flag is raised.

Top module: `uart_rx_packer`

## Requirements
- R1: Bytes are packed little-endian: the first byte of a row appears on `rd_word[7:0]` and the fourth on `rd_word[31:24]`. A row closed by its fourth byte is reported with `rd_count` = 4.
- R2: When `cfg_gap` is 0 and `cfg_match_en` is 0, one to three bytes of an unfinished row never raise `data_ready`, however many ticks go by.
- R3: When `cfg_gap` is N > 0, a partial row closes on the clock edge after the Nth `tick` that follows its most recent byte. Any received byte restarts that count.
- R4: With `cfg_match_en` high, a byte equal to `cfg_match_char` is stored in the current row, and that row closes at once with its byte count.
- R5: Lanes of a partial row that hold no data read as zero. `rd_count` (1 to 4) gives the number of lanes that hold data.
- R6: `data_ready` is registered. It rises on the edge that stores a row and falls on the edge that removes the last row. A high `rd_strobe` sampled at an edge removes the head row on that edge. Rows come out in the order they closed.
- R7: Each row close sets status bit 0. Writing a one to `stat_clr[0]` clears it, and a set in the same cycle wins over the clear.
- R8: Suppose a byte would close a row while 4 rows are stored and no pop happens in that cycle. That byte is dropped and status bit 1 is set. The stored rows and the partial row are kept as they were. `stat_clr[1]` clears the bit.
- R9: After reset, `data_ready` is 0 and both status bits are 0.
- R10: A `rd_strobe` while `data_ready` is low has no effect on the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | Received byte |
| tick | input | 1 | One-cycle pulse per serial bit time |
| cfg_gap | input | GAP_W (8) | Idle gap in ticks that closes a partial row; 0 turns it off |
| cfg_match_en | input | 1 | Turns on closing a row on a match character |
| cfg_match_char | input | 8 | Byte value that closes a row |
| rd_strobe | input | 1 | Remove the head row |
| rd_word | output | 32 | Head row data |
| rd_count | output | 3 | Number of lanes in the head row that hold data (1 to 4) |
| data_ready | output | 1 | At least one row is stored |
| stat_flags | output | 2 | Bit 0 is row-closed, bit 1 is overrun |
| stat_clr | input | 2 | Write-one-to-clear for `stat_flags` |

## Verification
The assertions assume the configuration inputs do not change while a partial row is in progress. They also assume `tick` and `byte_valid` are single-cycle pulses, as they would be from a bit-rate receiver. The stimulus sets `cfg_*` only while the packer is idle, and it drives each byte and each tick as one pulse on a falling edge. The bench never drives a byte and a tick in the same cycle, so the gap count follows a known order.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int STAT_W      = 2;
  localparam int STAT_CLOSED = 0;
  localparam int STAT_OVR    = 1;
  localparam int LANE_W      = 8;
endpackage

// File: rtl/rxp_packer.sv
module rxp_packer #(
  parameter int BYTES = 4,
  parameter int CW    = 3,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic          match_en,
  input  logic [7:0]    match_char,
  input  logic          gap_expired,
  input  logic          room,
  output logic          push,
  output logic [DW-1:0] push_row,
  output logic [CW-1:0] push_cnt,
  output logic          drop,
  output logic          busy
);
  logic [DW-1:0] acc_q, acc_d, ins_row;
  logic [CW-1:0] fill_q, fill_d;
  logic          hit, last;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign ins_row[i*8 +: 8] = (fill_q == CW'(i)) ? byte_data : acc_q[i*8 +: 8];
  end

  assign hit  = match_en && (byte_data == match_char);
  assign last = (fill_q == CW'(BYTES-1));
  assign busy = (fill_q != '0);

  always_comb begin
    push     = 1'b0;
    drop     = 1'b0;
    push_row = ins_row;
    push_cnt = fill_q + CW'(1);
    acc_d    = acc_q;
    fill_d   = fill_q;
    if (byte_valid) begin
      if (hit || last) begin
        if (room) begin
          push   = 1'b1;
          acc_d  = '0;
          fill_d = '0;
        end else begin
          drop = 1'b1;
        end
      end else begin
        acc_d  = ins_row;
        fill_d = fill_q + CW'(1);
      end
    end else if (gap_expired && busy && room) begin
      push     = 1'b1;
      push_row = acc_q;
      push_cnt = fill_q;
      acc_d    = '0;
      fill_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/rxp_gap_timer.sv
module rxp_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             tick,
  input  logic             restart,
  input  logic             busy,
  output logic             expired
);
  logic [GAP_W-1:0] cnt_q;
  logic             enabled;

  assign enabled = (cfg_gap != '0);
  assign expired = enabled && (cnt_q >= cfg_gap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!enabled || restart || !busy) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q < cfg_gap)) begin
      cnt_q <= cnt_q + GAP_W'(1);
    end
  end
endmodule

// File: rtl/rxp_row_fifo.sv
module rxp_row_fifo #(
  parameter int DEPTH = 4,
  parameter int CW    = 3,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_word,
  input  logic [CW-1:0] push_cnt,
  input  logic          pop_req,
  output logic [DW-1:0] head_word,
  output logic [CW-1:0] head_cnt,
  output logic          ready,
  output logic          full,
  output logic          room
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = AW + 1;

  logic [DW-1:0] mem_word [DEPTH];
  logic [CW-1:0] mem_cnt  [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [NW-1:0] count_q, count_d;
  logic          pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (count_q == NW'(DEPTH));
  assign pop       = pop_req && (count_q != '0);
  assign room      = !full || pop;
  assign head_word = mem_word[rd_ptr];
  assign head_cnt  = mem_cnt[rd_ptr];

  always_comb begin
    count_d = count_q;
    if (push && !pop)      count_d = count_q + NW'(1);
    else if (pop && !push) count_d = count_q - NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      ready   <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count_q <= count_d;
      ready   <= (count_d != '0);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_word[i] <= '0;
        mem_cnt[i]  <= '0;
      end else if (push && (wr_ptr == AW'(i))) begin
        mem_word[i] <= push_word;
        mem_cnt[i]  <= push_cnt;
      end
    end
  end
endmodule

// File: rtl/rxp_status.sv
module rxp_status
  import rxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set,
  input  logic [STAT_W-1:0] clr,
  output logic [STAT_W-1:0] flags
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_packer.sv
module uart_rx_packer
  import rxp_pkg::*;
#(
  parameter  int ROW_BYTES = 4,
  parameter  int DEPTH     = 4,
  parameter  int GAP_W     = 8,
  localparam int CW        = $clog2(ROW_BYTES + 1),
  localparam int DW        = LANE_W * ROW_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              tick,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              cfg_match_en,
  input  logic [7:0]        cfg_match_char,
  input  logic              rd_strobe,
  output logic [DW-1:0]     rd_word,
  output logic [CW-1:0]     rd_count,
  output logic              data_ready,
  output logic [STAT_W-1:0] stat_flags,
  input  logic [STAT_W-1:0] stat_clr
);
  logic          row_push, byte_drop, acc_busy, gap_exp, fifo_room, fifo_full;
  logic [DW-1:0] row_word;
  logic [CW-1:0] row_cnt;
  logic [STAT_W-1:0] stat_set;

  rxp_packer #(.BYTES(ROW_BYTES), .CW(CW), .DW(DW)) packer_i (
    .clk(clk), .rst_n(rst_n),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .match_en(cfg_match_en), .match_char(cfg_match_char),
    .gap_expired(gap_exp), .room(fifo_room),
    .push(row_push), .push_row(row_word), .push_cnt(row_cnt),
    .drop(byte_drop), .busy(acc_busy)
  );

  rxp_gap_timer #(.GAP_W(GAP_W)) gap_i (
    .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap), .tick(tick),
    .restart(byte_valid), .busy(acc_busy), .expired(gap_exp)
  );

  rxp_row_fifo #(.DEPTH(DEPTH), .CW(CW), .DW(DW)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(row_push), .push_word(row_word), .push_cnt(row_cnt),
    .pop_req(rd_strobe),
    .head_word(rd_word), .head_cnt(rd_count),
    .ready(data_ready), .full(fifo_full), .room(fifo_room)
  );

  always_comb begin
    stat_set              = '0;
    stat_set[STAT_CLOSED] = row_push;
    stat_set[STAT_OVR]    = byte_drop;
  end

  rxp_status status_i (
    .clk(clk), .rst_n(rst_n), .set(stat_set), .clr(stat_clr), .flags(stat_flags)
  );
endmodule

// File: rtl/uart_rx_packer_chk.sv
module uart_rx_packer_chk #(
  parameter int BYTES = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_valid,
  input logic [7:0]    byte_data,
  input logic          match_en,
  input logic [7:0]    match_char,
  input logic          gap_expired,
  input logic          push,
  input logic [CW-1:0] push_cnt,
  input logic          drop,
  input logic          rd_strobe,
  input logic          data_ready,
  input logic [CW-1:0] rd_count,
  input logic [1:0]    stat_flags,
  input logic          fifo_full
);
  // R2/R4/R3: a short row only leaves on a match byte or a gap expiry
  a_r2_partial_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_cnt != CW'(BYTES)) |->
      (gap_expired || (byte_valid && match_en && byte_data == match_char)));

  // R5: a stored row always reports 1..BYTES valid lanes
  a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> (rd_count != '0 && rd_count <= CW'(BYTES)));

  // R7: closing a row raises the closed flag
  a_r7_closed_set: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> stat_flags[0]);

  // R8: a dropped byte raises overrun and keeps the stored rows
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> stat_flags[1]);

  a_r8_rows_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !rd_strobe) |=> data_ready);

  // R8: no row enters a full FIFO unless one leaves in the same cycle
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !(rd_strobe && data_ready)) |-> !push);

  // R10/R6: an empty FIFO stays empty without a push
  a_r10_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && !push) |=> !data_ready);
endmodule

bind uart_rx_packer uart_rx_packer_chk #(.BYTES(ROW_BYTES), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .byte_valid(byte_valid), .byte_data(byte_data),
  .match_en(cfg_match_en), .match_char(cfg_match_char),
  .gap_expired(gap_exp), .push(row_push), .push_cnt(row_cnt),
  .drop(byte_drop), .rd_strobe(rd_strobe), .data_ready(data_ready),
  .rd_count(rd_count), .stat_flags(stat_flags), .fifo_full(fifo_full)
);

// File: tb/uart_rx_packer_tb_top.sv
module uart_rx_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        tick = 1'b0;
  logic [7:0]  cfg_gap = '0;
  logic        cfg_match_en = 1'b0;
  logic [7:0]  cfg_match_char = '0;
  logic        rd_strobe = 1'b0;
  logic [31:0] rd_word;
  logic [2:0]  rd_count;
  logic        data_ready;
  logic [1:0]  stat_flags;
  logic [1:0]  stat_clr = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_packer dut_i (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .tick(tick), .cfg_gap(cfg_gap), .cfg_match_en(cfg_match_en),
    .cfg_match_char(cfg_match_char), .rd_strobe(rd_strobe), .rd_word(rd_word),
    .rd_count(rd_count), .data_ready(data_ready), .stat_flags(stat_flags),
    .stat_clr(stat_clr)
  );

  // byte, expected ready, expected word, expected count (match char 0x0D, gap off)
  localparam logic [43:0] VEC [NVEC] = '{
    {8'h11, 1'b0, 32'h0000_0000, 3'd0},
    {8'h22, 1'b0, 32'h0000_0000, 3'd0},
    {8'h33, 1'b0, 32'h0000_0000, 3'd0},
    {8'h44, 1'b1, 32'h4433_2211, 3'd4},
    {8'h55, 1'b0, 32'h0000_0000, 3'd0},
    {8'h0D, 1'b1, 32'h0000_0D55, 3'd2},
    {8'h0D, 1'b1, 32'h0000_000D, 3'd1},
    {8'hA1, 1'b0, 32'h0000_0000, 3'd0},
    {8'hA2, 1'b0, 32'h0000_0000, 3'd0},
    {8'hA3, 1'b0, 32'h0000_0000, 3'd0},
    {8'hA4, 1'b1, 32'hA4A3_A2A1, 3'd4},
    {8'h01, 1'b0, 32'h0000_0000, 3'd0},
    {8'h02, 1'b0, 32'h0000_0000, 3'd0},
    {8'h0D, 1'b1, 32'h000D_0201, 3'd3}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic send_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pop_row();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic clear_flags(input logic [1:0] m);
    @(negedge clk); stat_clr = m;
    @(negedge clk); stat_clr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(data_ready == 1'b0, "R9 ready", 32'(data_ready), 32'h0);
    check(stat_flags == 2'b00, "R9 flags", 32'(stat_flags), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: pop on empty has no effect
    pop_row();
    check(data_ready == 1'b0, "R10 empty pop", 32'(data_ready), 32'h0);

    // Table walk: R1, R4, R5, R6
    cfg_match_en = 1'b1; cfg_match_char = 8'h0D;
    for (int i = 0; i < NVEC; i++) begin
      send_byte(VEC[i][43:36]);
      check(data_ready == VEC[i][35], "R1/R4 ready", 32'(data_ready), 32'(VEC[i][35]));
      if (VEC[i][35]) begin
        check(rd_word == VEC[i][34:3], "R1/R5 word", rd_word, VEC[i][34:3]);
        check(rd_count == VEC[i][2:0], "R5 count", 32'(rd_count), 32'(VEC[i][2:0]));
        pop_row();
        check(data_ready == 1'b0, "R6 pop drop", 32'(data_ready), 32'h0);
      end
    end

    // R7: w1c on closed flag, other bit untouched
    check(stat_flags[0] == 1'b1, "R7 closed set", 32'(stat_flags), 32'h1);
    clear_flags(2'b10);
    check(stat_flags[0] == 1'b1, "R7 other clr", 32'(stat_flags), 32'h1);
    clear_flags(2'b01);
    check(stat_flags[0] == 1'b0, "R7 cleared", 32'(stat_flags), 32'h0);

    // R3: gap close, byte restarts count
    cfg_match_en = 1'b0; cfg_gap = 8'd5;
    send_byte(8'h5A);
    for (int k = 0; k < 3; k++) send_tick();
    send_byte(8'h5B);
    for (int k = 0; k < 4; k++) send_tick();
    check(data_ready == 1'b0, "R3 before gap", 32'(data_ready), 32'h0);
    send_tick();
    @(negedge clk);
    check(data_ready == 1'b1, "R3 gap close", 32'(data_ready), 32'h1);
    check(rd_word == 32'h0000_5B5A, "R3 word", rd_word, 32'h0000_5B5A);
    check(rd_count == 3'd2, "R3 count", 32'(rd_count), 32'h2);
    pop_row();

    // R2: no event, partial row stays hidden
    cfg_gap = 8'd0;
    send_byte(8'h61); send_byte(8'h62); send_byte(8'h63);
    for (int k = 0; k < 20; k++) send_tick();
    check(data_ready == 1'b0, "R2 hidden", 32'(data_ready), 32'h0);
    send_byte(8'h64);
    check(rd_word == 32'h6463_6261, "R2 full row", rd_word, 32'h6463_6261);
    pop_row();
    clear_flags(2'b11);

    // R8: overrun with 4 rows stored
    for (int k = 0; k < 16; k++) send_byte(8'(8'h40 + k));
    check(stat_flags[1] == 1'b0, "R8 no ovr yet", 32'(stat_flags), 32'h0);
    send_byte(8'h50); send_byte(8'h51); send_byte(8'h52);
    send_byte(8'h53);
    check(stat_flags[1] == 1'b1, "R8 overrun", 32'(stat_flags), 32'h2);
    for (int r = 0; r < 4; r++) begin
      logic [31:0] e;
      e = {8'(8'h43 + 4*r), 8'(8'h42 + 4*r), 8'(8'h41 + 4*r), 8'(8'h40 + 4*r)};
      check(rd_word == e, "R8/R6 order", rd_word, e);
      pop_row();
    end
    check(data_ready == 1'b0, "R6 flushed", 32'(data_ready), 32'h0);
    send_byte(8'hEE);
    check(rd_word == 32'hEE52_5150, "R8 partial kept", rd_word, 32'hEE52_5150);
    clear_flags(2'b10);
    check(stat_flags[1] == 1'b0, "R8 ovr cleared", 32'(stat_flags), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule